// File: doc/BRIEF.md
# Shared Work Queue Submission Port

This block is one shared submission queue inside a device. Many requesters write fixed-size work descriptors to a single address. Each descriptor holds an operation code, a set of parameter addresses, a completion-record address and a 20-bit process address space identifier. Because the identifier is the only thing that tells one requester's work from another's, the queue keeps it with the descriptor. It then presents it on the output, so that later memory traffic for that work can carry the same tag.

Submission is non-posted. Every write gets a 2-bit status one cycle later:

- accepted, when the descriptor was stored;
- retry, when every slot was taken;
- error, when the submission arrived without a valid identifier.

Occupancy lives only inside the block, so requesters never track how full the queue is. They simply resend after a retry. Stored descriptors leave in arrival order through a valid/ready consumer port.

Top module: `swq_port`

## Requirements
- R1: While `rst_ni` is low, and on the first sample after it is released, `deq_valid_o` and `rsp_valid_o` are both 0 and the queue holds no entry.
- R2: `rsp_valid_o` is 1 in the cycle right after each cycle with `sub_valid_i` high, and is 0 in the cycle after any cycle without a submission.
- R3: A submission with `sub_pasid_ok_i` = 1 and a free slot is answered with code 2'b00 (accepted), and its descriptor is stored.
- R4: A submission with `sub_pasid_ok_i` = 1 while all DEPTH slots are full and no dequeue happens in the same cycle is answered with code 2'b01 (retry), and its descriptor is never presented on the output.
- R5: A submission with `sub_pasid_ok_i` = 0 is answered with code 2'b10 (error) whatever the occupancy, and its descriptor is never presented on the output.
- R6: Stored descriptors appear on the output in arrival order. The operation code, every parameter address, the completion address and the 20-bit identifier appear unchanged.
- R7: The queue holds exactly DEPTH entries: DEPTH accepted submissions in a row without dequeue all succeed, and the next one is retried.
- R8: When the queue is full and a dequeue (`deq_valid_o` and `deq_ready_i`) happens in the same cycle as a valid submission, that submission is accepted and takes the freed slot.
- R9: While `deq_valid_o` is 1 and `deq_ready_i` is 0, the next cycle still shows `deq_valid_o` = 1 with the same identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; empties the queue |
| sub_valid_i | input | 1 | A submission is presented this cycle |
| sub_pasid_ok_i | input | 1 | The submission's identifier is valid |
| sub_pasid_i | input | 20 | Process address space identifier |
| sub_op_i | input | OP_W | Operation code |
| sub_param_i | input | NPARAM*ADDR_W | Parameter addresses, packed |
| sub_cmpl_i | input | ADDR_W | Completion-record address |
| rsp_valid_o | output | 1 | Status is valid (one cycle after the submission) |
| rsp_code_o | output | 2 | 00 accepted, 01 retry, 10 error |
| deq_valid_o | output | 1 | Head entry is available |
| deq_ready_i | input | 1 | Consumer takes the head entry |
| deq_pasid_o | output | 20 | Head identifier |
| deq_op_o | output | OP_W | Head operation code |
| deq_param_o | output | NPARAM*ADDR_W | Head parameter addresses |
| deq_cmpl_o | output | ADDR_W | Head completion-record address |

## Verification
The hardest case to reach from the ports is a full queue meeting a dequeue and a submission in the very same cycle. The stimulus table first fills all slots and proves the next write is retried. It then shows that an invalid identifier still gets an error on a full queue. Only after that does it raise `deq_ready_i` together with a new submission, and it expects acceptance and then the new entry at the tail of the drained order. Rejected identifiers are chosen so that, if either were stored by mistake, it would break the expected head sequence.

// File: rtl/swq_pkg.sv
package swq_pkg;
  localparam int PASID_W = 20;

  typedef enum logic [1:0] {
    RSP_ACCEPT = 2'b00,
    RSP_RETRY  = 2'b01,
    RSP_ERROR  = 2'b10
  } rsp_code_e;
endpackage

// File: rtl/swq_store.sv
module swq_store #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              not_empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign not_empty_o = (cnt_q != '0);
  assign full_o      = (cnt_q == CNT_W'(DEPTH));
  assign data_o      = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o |-> pop_i);
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> not_empty_o);
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/swq_status.sv
module swq_status
  import swq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sub_i,
  input  logic      id_ok_i,
  input  logic      room_i,
  output logic      rsp_valid_o,
  output rsp_code_e rsp_code_o
);
  rsp_code_e code_d;

  // identifier check wins over occupancy
  always_comb begin
    if (!id_ok_i)     code_d = RSP_ERROR;
    else if (!room_i) code_d = RSP_RETRY;
    else              code_d = RSP_ACCEPT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_code_o  <= RSP_ACCEPT;
    end else begin
      rsp_valid_o <= sub_i;
      if (sub_i) rsp_code_o <= code_d;
    end
  end
endmodule

// File: rtl/swq_port.sv
module swq_port
  import swq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int OP_W   = 8,
  parameter int ADDR_W = 32,
  parameter int NPARAM = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sub_valid_i,
  input  logic                     sub_pasid_ok_i,
  input  logic [PASID_W-1:0]       sub_pasid_i,
  input  logic [OP_W-1:0]          sub_op_i,
  input  logic [NPARAM*ADDR_W-1:0] sub_param_i,
  input  logic [ADDR_W-1:0]        sub_cmpl_i,
  output logic                     rsp_valid_o,
  output logic [1:0]               rsp_code_o,
  output logic                     deq_valid_o,
  input  logic                     deq_ready_i,
  output logic [PASID_W-1:0]       deq_pasid_o,
  output logic [OP_W-1:0]          deq_op_o,
  output logic [NPARAM*ADDR_W-1:0] deq_param_o,
  output logic [ADDR_W-1:0]        deq_cmpl_o
);
  localparam int DESC_W = PASID_W + OP_W + NPARAM*ADDR_W + ADDR_W;

  logic              full, deq_fire, room, push;
  logic [DESC_W-1:0] desc_in, desc_out;
  rsp_code_e         code;

  assign deq_fire = deq_valid_o && deq_ready_i;
  assign room     = !full || deq_fire;  // slot freed by dequeue is reusable at once
  assign push     = sub_valid_i && sub_pasid_ok_i && room;
  assign desc_in  = {sub_pasid_i, sub_op_i, sub_param_i, sub_cmpl_i};
  assign {deq_pasid_o, deq_op_o, deq_param_o, deq_cmpl_o} = desc_out;

  swq_store #(.DEPTH(DEPTH), .DATA_W(DESC_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .data_i      (desc_in),
    .pop_i       (deq_fire),
    .data_o      (desc_out),
    .not_empty_o (deq_valid_o),
    .full_o      (full)
  );

  swq_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sub_i       (sub_valid_i),
    .id_ok_i     (sub_pasid_ok_i),
    .room_i      (room),
    .rsp_valid_o (rsp_valid_o),
    .rsp_code_o  (code)
  );
  assign rsp_code_o = code;

  assert_rsp_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_i |=> rsp_valid_o);
  assert_rsp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_valid_i |=> !rsp_valid_o);
  assert_error_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_i && !sub_pasid_ok_i |=> rsp_code_o == RSP_ERROR);
  assert_retry_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_i && sub_pasid_ok_i && full && !deq_ready_i |=> rsp_code_o == RSP_RETRY);
  assert_accept_swap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_i && sub_pasid_ok_i && full && deq_ready_i |=> rsp_code_o == RSP_ACCEPT);
  assert_hold_head_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deq_valid_o && !deq_ready_i |=> deq_valid_o && $stable(deq_pasid_o));
endmodule

// File: tb/swq_port_test.sv
module swq_port_test;
  localparam int DEPTH = 4, OP_W = 8, ADDR_W = 32, NPARAM = 2, PW = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sub_valid = 1'b0, sub_ok = 1'b0, deq_ready = 1'b0;
  logic [PW-1:0] sub_pasid = '0;
  logic [OP_W-1:0] sub_op = '0;
  logic [NPARAM*ADDR_W-1:0] sub_param = '0;
  logic [ADDR_W-1:0] sub_cmpl = '0;
  logic rsp_valid, deq_valid;
  logic [1:0] rsp_code;
  logic [PW-1:0] deq_pasid;
  logic [OP_W-1:0] deq_op;
  logic [NPARAM*ADDR_W-1:0] deq_param;
  logic [ADDR_W-1:0] deq_cmpl;

  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  swq_port #(.DEPTH(DEPTH), .OP_W(OP_W), .ADDR_W(ADDR_W), .NPARAM(NPARAM)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .sub_valid_i(sub_valid), .sub_pasid_ok_i(sub_ok), .sub_pasid_i(sub_pasid),
    .sub_op_i(sub_op), .sub_param_i(sub_param), .sub_cmpl_i(sub_cmpl),
    .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code),
    .deq_valid_o(deq_valid), .deq_ready_i(deq_ready),
    .deq_pasid_o(deq_pasid), .deq_op_o(deq_op),
    .deq_param_o(deq_param), .deq_cmpl_o(deq_cmpl)
  );

  // descriptor fields derived from identifier
  function automatic logic [OP_W-1:0] f_op(input logic [PW-1:0] p);
    return p[7:0] ^ 8'h5A;
  endfunction
  function automatic logic [NPARAM*ADDR_W-1:0] f_param(input logic [PW-1:0] p);
    return {32'(p) ^ 32'hA5A5_0000, 32'(p) + 32'h0001_0000};
  endfunction
  function automatic logic [ADDR_W-1:0] f_cmpl(input logic [PW-1:0] p);
    return {p, 12'hC40};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_head(input string req, input logic [PW-1:0] p);
    chk(req, 64'(deq_pasid), 64'(p));
    chk(req, 64'(deq_op), 64'(f_op(p)));
    chk(req, deq_param[63:0], f_param(p));
    chk(req, 64'(deq_cmpl), 64'(f_cmpl(p)));
  endtask

  task automatic drive(input logic v, input logic ok, input logic [PW-1:0] p, input logic rdy);
    sub_valid = v; sub_ok = ok; sub_pasid = p;
    sub_op = f_op(p); sub_param = f_param(p); sub_cmpl = f_cmpl(p);
    deq_ready = rdy;
  endtask

  typedef struct packed {
    logic          sub;
    logic          ok;
    logic          rdy;
    logic          edv;
    logic [PW-1:0] ehead;
    logic [PW-1:0] pasid;
    logic          erv;
    logic [1:0]    ecode;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,20'h0,    20'hF0011,1'b1,2'b00},  // R3
    '{1'b1,1'b1,1'b0,1'b1,20'hF0011,20'hF0022,1'b1,2'b00},
    '{1'b1,1'b0,1'b0,1'b1,20'hF0011,20'hF0033,1'b1,2'b10},  // R5
    '{1'b1,1'b1,1'b0,1'b1,20'hF0011,20'hF0044,1'b1,2'b00},
    '{1'b1,1'b1,1'b0,1'b1,20'hF0011,20'hF0055,1'b1,2'b00},  // R7 4th fits
    '{1'b1,1'b1,1'b0,1'b1,20'hF0011,20'hF0066,1'b1,2'b01},  // R4 R7
    '{1'b1,1'b0,1'b0,1'b1,20'hF0011,20'hF0077,1'b1,2'b10},  // R5 full
    '{1'b0,1'b0,1'b0,1'b1,20'hF0011,20'h0,    1'b0,2'b00},  // R2 idle
    '{1'b1,1'b1,1'b1,1'b1,20'hF0011,20'hF0088,1'b1,2'b00},  // R8
    '{1'b0,1'b0,1'b1,1'b1,20'hF0022,20'h0,    1'b0,2'b00},  // R6
    '{1'b0,1'b0,1'b1,1'b1,20'hF0044,20'h0,    1'b0,2'b00},
    '{1'b1,1'b1,1'b0,1'b1,20'hF0055,20'hF0099,1'b1,2'b00},
    '{1'b0,1'b0,1'b1,1'b1,20'hF0055,20'h0,    1'b0,2'b00},
    '{1'b0,1'b0,1'b1,1'b1,20'hF0088,20'h0,    1'b0,2'b00},
    '{1'b0,1'b0,1'b1,1'b1,20'hF0099,20'h0,    1'b0,2'b00},
    '{1'b0,1'b0,1'b1,1'b0,20'h0,    20'h0,    1'b0,2'b00}
  };

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset deq_valid", 64'(deq_valid), 0);
    chk("R1 reset rsp_valid", 64'(rsp_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release deq_valid", 64'(deq_valid), 0);
    chk("R1 after release rsp_valid", 64'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].sub, VEC[i].ok, VEC[i].pasid, VEC[i].rdy);
      #1;
      chk($sformatf("R6 step%0d deq_valid", i), 64'(deq_valid), 64'(VEC[i].edv));
      if (VEC[i].edv) chk_head($sformatf("R6 step%0d head", i), VEC[i].ehead);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2 step%0d rsp_valid", i), 64'(rsp_valid), 64'(VEC[i].erv));
      if (VEC[i].erv)
        chk($sformatf("R3/R4/R5 step%0d code", i), 64'(rsp_code), 64'(VEC[i].ecode));
    end

    // R9: stalled head stays put
    drive(1'b1, 1'b1, 20'h0ABCD, 1'b0);
    @(posedge clk); @(negedge clk);
    drive(1'b1, 1'b1, 20'h0BEEF, 1'b0);
    @(posedge clk); @(negedge clk);
    drive(1'b0, 1'b0, 20'h0, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R9 stalled valid", 64'(deq_valid), 1);
    chk_head("R9 stalled head", 20'h0ABCD);

    // R1: asynchronous reset mid-run empties the queue
    #2 rst_ni = 1'b0;
    #1;
    chk("R1 async reset deq_valid", 64'(deq_valid), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 empty after reset", 64'(deq_valid), 0);
    chk("R1 no rsp after reset", 64'(rsp_valid), 0);

    finish_run();
  end
endmodule